// File: doc/BRIEF.md
# Self-Repair Phase Sequencer

This block is the controller for an on-chip memory repair session. One start pulse launches a fixed series of phases. First the memory test engine runs, and the block records each failing address it reports into a small local log. If the test reports any failure, the logged addresses are passed one per cycle to a redundancy allocator, and the allocator is started. A solution that the allocator accepts is written to the remap registers with a single load strobe. The memory test then runs again on the repaired array. The session ends with a held status word: clean pass, repaired, not repairable, repair failed on re-test, or timeout.

The last accepted solution stays on the remap data output. A boot pulse strobes it into the remap registers again without running a test, so volatile repair registers can be refilled after power-up. Every phase that waits for an external done pulse is guarded by a cycle limit that the caller programs. The test algorithm and the permanent fuse programming are handled by other blocks.

Top module: `srp_sequencer`

## Requirements
- R1: A start pulse sampled while idle raises `tst_go` for exactly one cycle, in the cycle right after start. In that same cycle `busy` is 1 and `stat_valid` is 0. Every go pulse and every load strobe lasts one cycle.
- R2: If the first test reports done with `tst_fail`=0, the session ends with `stat`=1 (pass). `alloc_go` and `rmp_load` are never raised.
- R3: Each `fail_vld` address seen during the first test window, including the done cycle, is presented on `fl_vld`/`fl_addr`, one per cycle, in arrival order. `alloc_go` rises exactly two cycles after the last presented address.
- R4: If the allocator reports done with `alloc_ok`=0, the session ends with `stat`=3 (not repairable). No `rmp_load` is given and no second test is started.
- R5: If more than DEPTH failing addresses arrive in the first test, the session ends with `stat`=3 and the allocator is never started.
- R6: If the allocator reports done with `alloc_ok`=1, `rmp_load` pulses in the next cycle with `rmp_data` equal to `alloc_sol`. `tst_go` for the re-test pulses in the cycle after that.
- R7: If the re-test ends with `tst_fail`=0, `stat`=2 (repaired). If it ends with `tst_fail`=1, `stat`=4 (repair failed).
- R8: In each waiting phase, a done pulse is accepted when it arrives no more than `timeout_lim` cycles after the cycle of the matching go pulse. A done pulse exactly `timeout_lim` cycles after the go cycle is still accepted. If no done pulse arrives in that window, the session ends with `stat`=5 (timeout).
- R9: `stat` and `stat_valid`=1 hold unchanged after a session ends, until the next start pulse. `busy` and `stat_valid` are never both 1.
- R10: A start pulse while `busy` is 1 has no effect.
- R11: A `boot` pulse while idle, with no start pulse in the same cycle, raises `rmp_load` in the next cycle with `rmp_data` equal to the last accepted solution. If no solution has been accepted since reset, a boot pulse gives no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a repair session |
| boot | input | 1 | Reload the stored solution into the remap registers |
| timeout_lim | input | TW | Cycle limit for each wait on a done pulse |
| tst_go | output | 1 | Start pulse to the memory test engine |
| tst_done | input | 1 | Test engine finished |
| tst_fail | input | 1 | Test result at done: 1 means failures were seen |
| fail_vld | input | 1 | A failing address is present |
| fail_addr | input | AW | Failing address |
| fl_vld | output | 1 | Logged address presented to the allocator |
| fl_addr | output | AW | Logged address value |
| alloc_go | output | 1 | Start pulse to the allocator |
| alloc_done | input | 1 | Allocator finished |
| alloc_ok | input | 1 | At done: 1 means the spares cover all failures |
| alloc_sol | input | SW | Repair solution at done |
| rmp_load | output | 1 | Load strobe to the remap registers |
| rmp_data | output | SW | Solution to load, held between loads |
| busy | output | 1 | Session in progress |
| stat_valid | output | 1 | Final status is valid |
| stat | output | 3 | 0 none, 1 pass, 2 repaired, 3 not repairable, 4 repair failed, 5 timeout |

## Verification
A done pulse and the expiry of the phase cycle limit can land in the same cycle. The bench provokes this by sending each done pulse exactly `timeout_lim` cycles after its go pulse, in the detect, allocate and re-test phases in turn, and expects the normal outcome every time. One cycle later it expects a timeout status instead. A second collision comes from a boot pulse in the same cycle as start. The bench sees that the start wins and that no load strobe appears in a clean-pass session.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [2:0] {
    ST_NONE     = 3'd0,
    ST_PASS     = 3'd1,
    ST_REPAIRED = 3'd2,
    ST_NOSPARE  = 3'd3,
    ST_REPFAIL  = 3'd4,
    ST_TIMEOUT  = 3'd5
  } stat_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DWAIT,
    PH_FEED,
    PH_AWAIT,
    PH_APPLY,
    PH_RWAIT
  } phase_e;
endpackage

// File: rtl/srp_fail_log.sv
// Failing-address log: written during the first test, drained in order.
module srp_fail_log #(
  parameter int AW    = 10,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          rd_en,
  output logic [AW-1:0] rd_data,
  output logic          rd_vld,
  output logic          drained,
  output logic          ovf
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] wcnt;
  logic [PW-1:0] rptr;
  logic          do_wr;

  assign do_wr = wr_en && !clr && (wcnt != FULL);

  // RAM write port, no reset so block RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_wr) mem[wcnt[IW-1:0]] <= wr_addr;
  end

  // registered RAM read port
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rptr[IW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wcnt   <= '0;
      rptr   <= '0;
      ovf    <= 1'b0;
      rd_vld <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      if (do_wr) wcnt <= wcnt + 1'b1;
      if (wr_en && (wcnt == FULL)) ovf <= 1'b1;
      if (rd_en) rptr <= rptr + 1'b1;
    end
  end

  assign drained = (rptr == wcnt);
endmodule

// File: rtl/srp_phase_timer.sv
// Counts cycles spent in a waiting phase; flags the limit.
module srp_phase_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [TW-1:0] lim,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == lim);
endmodule

// File: rtl/srp_sequencer.sv
module srp_sequencer
  import srp_pkg::*;
#(
  parameter int AW    = 10,
  parameter int SW    = 16,
  parameter int DEPTH = 8,
  parameter int TW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          boot,
  input  logic [TW-1:0] timeout_lim,
  output logic          tst_go,
  input  logic          tst_done,
  input  logic          tst_fail,
  input  logic          fail_vld,
  input  logic [AW-1:0] fail_addr,
  output logic          fl_vld,
  output logic [AW-1:0] fl_addr,
  output logic          alloc_go,
  input  logic          alloc_done,
  input  logic          alloc_ok,
  input  logic [SW-1:0] alloc_sol,
  output logic          rmp_load,
  output logic [SW-1:0] rmp_data,
  output logic          busy,
  output logic          stat_valid,
  output logic [2:0]    stat
);
  phase_e ph, nxt;
  stat_e  stat_q, fin_code;
  logic   fin, go_t, go_a, ld_sol, boot_ld, sol_ok;
  logic   run_tmr, expired;
  logic   log_clr, log_wr, log_rd, log_drained, log_ovf;

  assign log_clr = (ph == PH_IDLE) && start;
  assign log_wr  = (ph == PH_DWAIT) && fail_vld;
  assign log_rd  = (ph == PH_FEED) && !log_drained && !log_ovf;
  assign run_tmr = (ph == PH_DWAIT) || (ph == PH_AWAIT) || (ph == PH_RWAIT);
  assign boot_ld = (ph == PH_IDLE) && !start && boot && sol_ok;

  srp_fail_log #(.AW(AW), .DEPTH(DEPTH)) u_log (
    .clk     (clk),
    .rst     (rst),
    .clr     (log_clr),
    .wr_en   (log_wr),
    .wr_addr (fail_addr),
    .rd_en   (log_rd),
    .rd_data (fl_addr),
    .rd_vld  (fl_vld),
    .drained (log_drained),
    .ovf     (log_ovf)
  );

  srp_phase_timer #(.TW(TW)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .run     (run_tmr),
    .lim     (timeout_lim),
    .expired (expired)
  );

  always_comb begin
    nxt      = ph;
    fin      = 1'b0;
    fin_code = ST_NONE;
    go_t     = 1'b0;
    go_a     = 1'b0;
    ld_sol   = 1'b0;
    case (ph)
      PH_IDLE: begin
        if (start) begin
          nxt  = PH_DWAIT;
          go_t = 1'b1;
        end
      end
      PH_DWAIT: begin
        if (tst_done) begin
          if (!tst_fail) begin
            fin      = 1'b1;
            fin_code = ST_PASS;
          end else begin
            nxt = PH_FEED;
          end
        end else if (expired) begin
          fin      = 1'b1;
          fin_code = ST_TIMEOUT;
        end
      end
      PH_FEED: begin
        if (log_ovf) begin
          fin      = 1'b1;
          fin_code = ST_NOSPARE;
        end else if (log_drained && !fl_vld) begin
          nxt  = PH_AWAIT;
          go_a = 1'b1;
        end
      end
      PH_AWAIT: begin
        if (alloc_done) begin
          if (alloc_ok) begin
            nxt    = PH_APPLY;
            ld_sol = 1'b1;
          end else begin
            fin      = 1'b1;
            fin_code = ST_NOSPARE;
          end
        end else if (expired) begin
          fin      = 1'b1;
          fin_code = ST_TIMEOUT;
        end
      end
      PH_APPLY: begin
        nxt  = PH_RWAIT;
        go_t = 1'b1;
      end
      PH_RWAIT: begin
        if (tst_done) begin
          fin      = 1'b1;
          fin_code = tst_fail ? ST_REPFAIL : ST_REPAIRED;
        end else if (expired) begin
          fin      = 1'b1;
          fin_code = ST_TIMEOUT;
        end
      end
      default: nxt = PH_IDLE;
    endcase
    if (fin) nxt = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= PH_IDLE;
      tst_go     <= 1'b0;
      alloc_go   <= 1'b0;
      rmp_load   <= 1'b0;
      rmp_data   <= '0;
      sol_ok     <= 1'b0;
      busy       <= 1'b0;
      stat_valid <= 1'b0;
      stat_q     <= ST_NONE;
    end else begin
      ph       <= nxt;
      tst_go   <= go_t;
      alloc_go <= go_a;
      rmp_load <= ld_sol || boot_ld;
      if (ld_sol) begin
        rmp_data <= alloc_sol;
        sol_ok   <= 1'b1;
      end
      if (log_clr) begin
        busy       <= 1'b1;
        stat_valid <= 1'b0;
        stat_q     <= ST_NONE;
      end else if (fin) begin
        busy       <= 1'b0;
        stat_valid <= 1'b1;
        stat_q     <= fin_code;
      end
    end
  end

  assign stat = stat_q;
endmodule

// File: rtl/srp_chk.sv
module srp_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       tst_go,
  input logic       alloc_go,
  input logic       alloc_done,
  input logic       alloc_ok,
  input logic       rmp_load,
  input logic       fl_vld,
  input logic       busy,
  input logic       stat_valid,
  input logic [2:0] stat
);
  // R1
  tgo_single_chk: assert property (@(posedge clk) disable iff (rst)
    tst_go |=> !tst_go);
  // R1
  ago_single_chk: assert property (@(posedge clk) disable iff (rst)
    alloc_go |=> !alloc_go);
  // R4
  no_load_on_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && alloc_done && !alloc_ok && !tst_go && !alloc_go) |=> !rmp_load);
  // R6
  retest_after_apply_chk: assert property (@(posedge clk) disable iff (rst)
    (rmp_load && busy) |=> tst_go);
  // R9
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_valid && !start) |=> (stat_valid && $stable(stat)));
  // R9
  busy_excl_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !stat_valid);
  // R3
  feed_in_session_chk: assert property (@(posedge clk) disable iff (rst)
    fl_vld |-> (busy && !tst_go && !alloc_go));
endmodule

bind srp_sequencer srp_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .tst_go     (tst_go),
  .alloc_go   (alloc_go),
  .alloc_done (alloc_done),
  .alloc_ok   (alloc_ok),
  .rmp_load   (rmp_load),
  .fl_vld     (fl_vld),
  .busy       (busy),
  .stat_valid (stat_valid),
  .stat       (stat)
);

// File: tb/sim_srp_sequencer.sv
module sim_srp_sequencer;
  localparam int AW = 10, SW = 16, DEPTH = 8, TW = 8, LIM = 12;

  logic clk = 0, rst = 1, start = 0, boot = 0;
  logic [TW-1:0] timeout_lim = TW'(LIM);
  logic tst_done = 0, tst_fail = 0, fail_vld = 0;
  logic [AW-1:0] fail_addr = '0;
  logic alloc_done = 0, alloc_ok = 0;
  logic [SW-1:0] alloc_sol = '0;
  logic tst_go, fl_vld, alloc_go, rmp_load, busy, stat_valid;
  logic [AW-1:0] fl_addr;
  logic [SW-1:0] rmp_data;
  logic [2:0] stat;

  int n_run = 0, n_bad = 0;
  int cyc = 0, n_tgo = 0, n_ago = 0, n_load = 0, n_fl = 0;
  int t_tgo = 0, t_ago = 0, t_load = 0, t_fl = 0;
  logic [AW-1:0] fl_buf [16];
  logic [SW-1:0] last_sol = '0;

  always #4 clk = ~clk;

  srp_sequencer #(.AW(AW), .SW(SW), .DEPTH(DEPTH), .TW(TW)) u0 (
    .clk(clk), .rst(rst), .start(start), .boot(boot), .timeout_lim(timeout_lim),
    .tst_go(tst_go), .tst_done(tst_done), .tst_fail(tst_fail),
    .fail_vld(fail_vld), .fail_addr(fail_addr),
    .fl_vld(fl_vld), .fl_addr(fl_addr),
    .alloc_go(alloc_go), .alloc_done(alloc_done), .alloc_ok(alloc_ok),
    .alloc_sol(alloc_sol), .rmp_load(rmp_load), .rmp_data(rmp_data),
    .busy(busy), .stat_valid(stat_valid), .stat(stat));

  always @(negedge clk) begin
    cyc++;
    if (tst_go)   begin n_tgo++;  t_tgo = cyc;  end
    if (alloc_go) begin n_ago++;  t_ago = cyc;  end
    if (rmp_load) begin n_load++; t_load = cyc; end
    if (fl_vld)   begin fl_buf[n_fl % 16] = fl_addr; n_fl++; t_fl = cyc; end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] addr_of(input int n, input int i);
    return AW'((n * 37 + i * 13 + 5) % 1024);
  endfunction

  task automatic session(input int nf, input bit ok, input bit rt_bad,
                         input int dd, input int da, input int dr,
                         input bit xstart, input bit bwith);
    int b_tgo, b_ago, b_load, b_fl;
    int e_code, e_tgo, e_ago, e_load, e_fl, kmax;
    string rq;
    logic [SW-1:0] sol;
    sol = SW'(16'hA500 + nf * 16 + int'(ok) * 2 + int'(rt_bad));
    b_tgo = n_tgo; b_ago = n_ago; b_load = n_load; b_fl = n_fl;
    e_tgo = 1; e_ago = 0; e_load = 0; e_fl = 0;
    if (dd > LIM)            begin e_code = 5; rq = "R8"; end
    else if (nf == 0)        begin e_code = 1; rq = "R2"; end
    else if (nf > DEPTH)     begin e_code = 3; rq = "R5"; end
    else begin
      e_fl = nf; e_ago = 1;
      if (da > LIM)          begin e_code = 5; rq = "R8"; end
      else if (!ok)          begin e_code = 3; rq = "R4"; end
      else begin
        e_load = 1; e_tgo = 2;
        if (dr > LIM)        begin e_code = 5; rq = "R8"; end
        else begin e_code = rt_bad ? 4 : 2; rq = "R7"; end
      end
    end
    start = 1; boot = bwith;
    step();
    start = 0; boot = 0;
    // R1: go pulse in the cycle after start, busy up, status cleared
    check(tst_go && busy && !stat_valid, "R1", int'(tst_go), 1);
    kmax = (nf > dd) ? nf : dd;
    for (int k = 1; k <= kmax; k++) begin
      step();
      fail_vld  = (k <= nf);
      fail_addr = addr_of(nf, k - 1);
      tst_done  = (k == dd) && (dd <= LIM);
      tst_fail  = (nf > 0);
      start     = xstart && (k == 2);
    end
    step();
    fail_vld = 0; tst_done = 0; start = 0;
    if (e_ago > 0) begin
      for (int i = 0; i < 60 && !alloc_go; i++) step();
      for (int k = 1; k <= da; k++) begin
        step();
        alloc_done = (k == da) && (da <= LIM);
        alloc_ok = ok; alloc_sol = sol;
      end
      step();
      alloc_done = 0;
      if (e_load > 0) begin
        for (int i = 0; i < 60 && !tst_go; i++) step();
        for (int k = 1; k <= dr; k++) begin
          step();
          tst_done = (k == dr) && (dr <= LIM);
          tst_fail = rt_bad;
        end
        step();
        tst_done = 0;
      end
    end
    for (int i = 0; i < 80 && !stat_valid; i++) step();
    check(stat_valid && int'(stat) == e_code, rq, int'(stat), e_code);
    // R1 R10: number of test starts
    check(n_tgo - b_tgo == e_tgo, xstart ? "R10" : "R1", n_tgo - b_tgo, e_tgo);
    check(n_ago - b_ago == e_ago, "R5", n_ago - b_ago, e_ago);
    check(n_load - b_load == e_load, bwith ? "R11" : "R4", n_load - b_load, e_load);
    check(n_fl - b_fl == e_fl, "R3", n_fl - b_fl, e_fl);
    for (int i = 0; i < e_fl && i < n_fl - b_fl; i++)
      check(fl_buf[(b_fl + i) % 16] == addr_of(nf, i), "R3",
            int'(fl_buf[(b_fl + i) % 16]), int'(addr_of(nf, i)));
    if (e_fl > 0) check(t_ago == t_fl + 2, "R3", t_ago - t_fl, 2);
    if (e_load > 0) begin
      check(rmp_data == sol, "R6", int'(rmp_data), int'(sol));
      check(t_tgo == t_load + 1, "R6", t_tgo - t_load, 1);
      last_sol = sol;
    end
    repeat (5) step();
    // R9: status held while idle
    check(stat_valid && !busy && int'(stat) == e_code, "R9", int'(stat), e_code);
  endtask

  initial begin
    #(8 * 200000);
    n_run++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    int b;
    repeat (3) step();
    rst = 0;
    step();
    check(!busy && !stat_valid && stat == 3'd0, "R9", int'(stat), 0);
    check(!tst_go && !alloc_go && !rmp_load && !fl_vld, "R1", int'(tst_go), 0);
    // R11: boot with nothing stored gives no load
    b = n_load;
    boot = 1; step(); boot = 0; repeat (3) step();
    check(n_load == b, "R11", n_load - b, 0);
    // sweep over failure counts, allocator answers and re-test outcomes
    for (int nf = 0; nf <= DEPTH + 1; nf++)
      for (int ok = 0; ok < 2; ok++)
        for (int rb = 0; rb < 2; rb++)
          session(nf, ok[0], rb[0], nf + 1, 1 + nf % 3, 2 + rb, 1'b0, 1'b0);
    // R11: boot after a repair reloads the last accepted solution
    boot = 1; step(); boot = 0;
    check(rmp_load && rmp_data == last_sol, "R11", int'(rmp_data), int'(last_sol));
    step();
    check(!rmp_load, "R11", int'(rmp_load), 0);
    // R8: done exactly at the limit vs one cycle late, per phase
    session(0, 1'b1, 1'b0, LIM,     1,       1,       1'b0, 1'b0);
    session(0, 1'b1, 1'b0, LIM + 1, 1,       1,       1'b0, 1'b0);
    session(3, 1'b1, 1'b0, 4,       LIM,     1,       1'b0, 1'b0);
    session(3, 1'b1, 1'b0, 4,       LIM + 1, 1,       1'b0, 1'b0);
    session(2, 1'b1, 1'b0, 3,       2,       LIM,     1'b0, 1'b0);
    session(2, 1'b1, 1'b0, 3,       2,       LIM + 1, 1'b0, 1'b0);
    session(DEPTH, 1'b1, 1'b1, DEPTH, 1, 1, 1'b0, 1'b0);
    // R10: start while busy ignored
    session(0, 1'b0, 1'b0, 5, 1, 1, 1'b1, 1'b0);
    session(4, 1'b1, 1'b0, 6, 2, 2, 1'b1, 1'b0);
    // R11: boot together with start is dropped
    session(0, 1'b0, 1'b0, 2, 1, 1, 1'b0, 1'b1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule